// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects up to 32 interrupt sources and presents one request line to the processor. Each source has a mode word and a vector word. The mode word sets an eight-level priority and one of four trigger types. The vector word is the value software gets back when that source is serviced. The block runs the arbitration itself. Among the enabled pending sources it finds the one with the highest priority whose level is above the priority now being serviced, and it raises the request line while such a source exists.

Software services a request in three steps. It reads the vector location, which acknowledges the winner and records its priority on an eight-entry nesting stack. It runs the handler. It then writes the end-of-interrupt location, which removes the top stack entry. Further locations let software enable and disable sources, clear or force pending bits, set the value returned when nothing is waiting, and turn on a protect mode in which vector reads have no side effects. Every access is a single-cycle 32-bit read or write strobe. Read data is registered and appears after the clock edge that samples the read strobe.

Top module: `vic_top`

## Requirements
- R1: Source n has a mode word at byte address n*4. The priority sits in bits [2:0], where 7 is the most urgent, and the trigger type sits in bits [6:5]. All other bits read 0. After reset every mode word reads 0x40, which is high level at priority 0.
- R2: Trigger codes are 0 = low level, 1 = falling edge, 2 = high level and 3 = rising edge. Source 0 and sources flagged in the external-source parameter keep all four codes. On every other source, bit 6 is forced to 1, so code 0 is stored as 2 and code 1 is stored as 3.
- R3: Source n has a read/write vector word at byte address 0x80 + n*4.
- R4: A write to 0x120 sets the enable bits given as ones in the data. A write to 0x124 clears the enable bits given as ones. Zero bits leave their enable unchanged. The enable word reads at 0x110.
- R5: A write to 0x12C forces the pending bits given as ones, whatever their trigger type. A write to 0x128 clears the latched pending bits given as ones. The pending word reads at 0x10C.
- R6: Inputs pass through a two-flop synchronizer. An edge type latches pending on its edge and holds it until it is acknowledged or cleared. A level type is pending while its synchronized input is at the active level.
- R7: The request output, mirrored at 0x114 bit 0, is high exactly when some enabled pending source has a priority strictly above the top stack entry, or when the stack is empty and some enabled source is pending.
- R8: With protect mode off, a read of 0x100 returns the vector of the most urgent eligible source, and ties go to the lowest source number. The same read pushes that source's priority, stores its number for reading at 0x108, and clears its latched pending bit.
- R9: When no source is eligible, a read of 0x100 returns the spurious value, which is read/write at 0x134 and resets to 0. The read sets 0x108 to 0 and pushes nothing.
- R10: A write to 0x130 pops one stack entry and has no effect on an empty stack. The stack holds at most 8 entries, so eight such writes always empty it.
- R11: Bit 0 of 0x138 selects protect mode, and reset clears it. In protect mode a read of 0x100 returns the same value but pushes nothing, acknowledges nothing and leaves 0x108 unchanged.
- R12: A level-type source stays pending while its input remains active, even after a clear-pending write or an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | NUM_SRC | Raw interrupt inputs |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
Directed sequences first cover each trigger type. They check that a low-level source clears when its input returns, that an edge latch outlives its pulse, and that a rising edge fires only once while the input stays high. Hand-built nesting cases separate a strictly-higher priority from an equal one and a tied priority from a lower source number. They also separate a real acknowledge from a protect-mode read and from a spurious read. Random rounds then assign new priorities, vectors, enables and forced pending sets, and mix vector reads with end-of-interrupt writes. A bench model of the stack predicts the request line, each returned vector and each stored source number, which exercises the ordering rule across many pending combinations.

// File: rtl/vic_pkg.sv
// Shared address map and trigger encoding for the vectored interrupt controller.
// Assumes a 9-bit byte address. Mode words occupy 0x000-0x07C and vector words 0x080-0x0FC.
package vic_pkg;

    localparam int unsigned ADDR_W = 9;

    localparam logic [ADDR_W-1:0] A_VECT_RD  = 9'h100;
    localparam logic [ADDR_W-1:0] A_CUR_SRC  = 9'h108;
    localparam logic [ADDR_W-1:0] A_PEND     = 9'h10C;
    localparam logic [ADDR_W-1:0] A_ENABLED  = 9'h110;
    localparam logic [ADDR_W-1:0] A_CORE     = 9'h114;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 9'h120;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 9'h124;
    localparam logic [ADDR_W-1:0] A_PND_CLR  = 9'h128;
    localparam logic [ADDR_W-1:0] A_PND_SET  = 9'h12C;
    localparam logic [ADDR_W-1:0] A_EOI      = 9'h130;
    localparam logic [ADDR_W-1:0] A_SPUR     = 9'h134;
    localparam logic [ADDR_W-1:0] A_PROTECT  = 9'h138;

    // Bit 1 of the code selects polarity (1 = high/rising), bit 0 selects edge.
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_HIGH = 2'd2,
        TRIG_RISE = 2'd3
    } trig_e;

endpackage

// File: rtl/vic_src_cell.sv
// One interrupt source: a two-flop synchronizer, an edge detector and a pending latch.
// Assumes raw_in may be asynchronous. Pending is the latch OR the active input level
// for level types. Acknowledge and clear remove only the latch part.
module vic_src_cell
    import vic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  raw_in,
    input  trig_e trig,
    input  logic  sw_set,
    input  logic  sw_clr,
    input  logic  ack,
    output logic  pending
);

    logic [2:0] sync_q;     // [0],[1] synchronizer, [2] history for edge detect
    logic       latch_q;
    logic       line_now;
    logic       line_old;
    logic       edge_hit;
    logic       level_hit;

    assign line_now = sync_q[1];
    assign line_old = sync_q[2];

    // Synchronize the raw input and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], raw_in};
    end

    // Decode the trigger type into an edge event and an active level.
    always_comb begin
        edge_hit  = 1'b0;
        level_hit = 1'b0;
        unique case (trig)
            TRIG_RISE: edge_hit  = line_now & ~line_old;
            TRIG_FALL: edge_hit  = ~line_now & line_old;
            TRIG_HIGH: level_hit = line_now;
            TRIG_LOW:  level_hit = ~line_now;
            default:   level_hit = 1'b0;
        endcase
    end

    // Latch edges and software sets; a fresh event in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= 1'b0;
        else        latch_q <= (latch_q & ~(sw_clr | ack)) | edge_hit | sw_set;
    end

    assign pending = latch_q | level_hit;

endmodule

// File: rtl/vic_arbiter.sv
// Combinational winner search over candidate sources.
// Assumes cand already combines pending and enable. A source is eligible when the
// floor is invalid (empty stack) or its priority is strictly above the floor.
// The highest priority wins and ties go to the lowest index.
module vic_arbiter #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned PRIO_W  = 3,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]             cand,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic                           floor_valid,
    input  logic [PRIO_W-1:0]              floor_level,
    output logic                           hit,
    output logic [IDX_W-1:0]               win_idx,
    output logic [PRIO_W-1:0]              win_prio
);

    // Scan from the top index down so an equal priority at a lower index replaces it.
    always_comb begin
        hit      = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i] && (!floor_valid || (prio[i] > floor_level))
                && (!hit || (prio[i] >= win_prio))) begin
                hit      = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i];
            end
        end
    end

endmodule

// File: rtl/vic_nest_stack.sv
// Stack of the priority levels now in service.
// Assumes push and pop never arrive in the same cycle. A push on a full stack and a
// pop on an empty stack are ignored.
module vic_nest_stack #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_lvl,
    input  logic              pop,
    output logic [CNT_W-1:0]  depth,
    output logic              nonempty,
    output logic [PRIO_W-1:0] top_lvl
);

    logic [DEPTH-1:0][PRIO_W-1:0] stk_q;
    logic [PTR_W-1:0]             wr_ptr;
    logic [PTR_W-1:0]             top_ptr;

    assign wr_ptr  = PTR_W'(depth);
    assign top_ptr = PTR_W'(depth - 1'b1);

    // Push the acknowledged level or pop the serviced one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
            stk_q <= '0;
        end else if (push && (depth != CNT_W'(DEPTH))) begin
            stk_q[wr_ptr] <= push_lvl;
            depth         <= depth + 1'b1;
        end else if (pop && (depth != '0)) begin
            depth <= depth - 1'b1;
        end
    end

    assign nonempty = (depth != '0);
    assign top_lvl  = stk_q[top_ptr];

endmodule

// File: rtl/vic_top.sv
// Vectored prioritized interrupt controller top: register file, per-source cells,
// arbitration and the nesting stack.
// Assumes NUM_SRC <= 32 and PRIO_W <= 5. Read data is registered, and vector-read side
// effects take place on the same edge that samples the read strobe.
module vic_top
    import vic_pkg::*;
#(
    parameter int unsigned          NUM_SRC      = 32,
    parameter int unsigned          PRIO_W       = 3,
    parameter int unsigned          NEST_DEPTH   = 8,
    parameter logic [NUM_SRC-1:0]   EXT_SRC_MASK = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [8:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq_req
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int unsigned CNT_W = $clog2(NEST_DEPTH + 1);
    localparam logic [NUM_SRC-1:0] EXT_MAP = EXT_SRC_MASK | NUM_SRC'(1);

    logic [NUM_SRC-1:0][PRIO_W-1:0] mode_prio;
    logic [NUM_SRC-1:0][1:0]        mode_trig;
    logic [NUM_SRC-1:0][31:0]       vec_tbl;
    logic [NUM_SRC-1:0]             en_mask;
    logic [31:0]                    spur_vec;
    logic                           prot_mode;
    logic [IDX_W-1:0]               cur_src;

    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] ack_vec;

    logic [IDX_W-1:0]   word_idx;
    logic               idx_ok;
    logic               in_mode;
    logic               in_vect;
    logic               vect_rd;
    logic               do_ack;
    logic               do_eoi;
    logic               arb_hit;
    logic [IDX_W-1:0]   win_idx;
    logic [PRIO_W-1:0]  win_prio;
    logic [CNT_W-1:0]   nest_depth;
    logic               nest_busy;
    logic [PRIO_W-1:0]  nest_top;
    logic [31:0]        rd_word;

    // Address decode for the per-source regions and the acknowledge/EOI strobes.
    assign word_idx = bus_addr[IDX_W+1:2];
    assign idx_ok   = (int'(word_idx) < NUM_SRC);
    assign in_mode  = (bus_addr[8:7] == 2'b00) && idx_ok;
    assign in_vect  = (bus_addr[8:7] == 2'b01) && idx_ok;
    assign vect_rd  = bus_rd && (bus_addr == A_VECT_RD);
    assign do_ack   = vect_rd && !prot_mode && arb_hit;
    assign do_eoi   = bus_wr && (bus_addr == A_EOI);

    // Mode and vector words; internal sources have the polarity bit forced high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_prio <= '0;
            mode_trig <= {NUM_SRC{2'b10}};
            vec_tbl   <= '0;
        end else if (bus_wr) begin
            if (in_mode) begin
                mode_prio[word_idx] <= bus_wdata[PRIO_W-1:0];
                mode_trig[word_idx] <= {bus_wdata[6] | ~EXT_MAP[word_idx], bus_wdata[5]};
            end
            if (in_vect) vec_tbl[word_idx] <= bus_wdata;
        end
    end

    // Enable mask, spurious value and protect flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_mask   <= '0;
            spur_vec  <= '0;
            prot_mode <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_EN_SET)  en_mask   <= en_mask | bus_wdata[NUM_SRC-1:0];
            if (bus_addr == A_EN_CLR)  en_mask   <= en_mask & ~bus_wdata[NUM_SRC-1:0];
            if (bus_addr == A_SPUR)    spur_vec  <= bus_wdata;
            if (bus_addr == A_PROTECT) prot_mode <= bus_wdata[0];
        end
    end

    // Software set/clear strobes for the pending latches.
    assign set_vec = (bus_wr && (bus_addr == A_PND_SET)) ? bus_wdata[NUM_SRC-1:0] : '0;
    assign clr_vec = (bus_wr && (bus_addr == A_PND_CLR)) ? bus_wdata[NUM_SRC-1:0] : '0;

    // One-hot acknowledge to the winning source.
    always_comb begin
        ack_vec = '0;
        if (do_ack) ack_vec[win_idx] = 1'b1;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        vic_src_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_in  (src_in[g]),
            .trig    (trig_e'(mode_trig[g])),
            .sw_set  (set_vec[g]),
            .sw_clr  (clr_vec[g]),
            .ack     (ack_vec[g]),
            .pending (pend_vec[g])
        );
    end

    vic_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W)
    ) u_arb (
        .cand        (pend_vec & en_mask),
        .prio        (mode_prio),
        .floor_valid (nest_busy),
        .floor_level (nest_top),
        .hit         (arb_hit),
        .win_idx     (win_idx),
        .win_prio    (win_prio)
    );

    vic_nest_stack #(
        .DEPTH  (NEST_DEPTH),
        .PRIO_W (PRIO_W)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_ack),
        .push_lvl (win_prio),
        .pop      (do_eoi),
        .depth    (nest_depth),
        .nonempty (nest_busy),
        .top_lvl  (nest_top)
    );

    assign irq_req = arb_hit;

    // Current source number: the winner on an acknowledge, zero on a spurious read.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cur_src <= '0;
        else if (vect_rd && !prot_mode) cur_src <= arb_hit ? win_idx : '0;
    end

    // Read multiplexer.
    always_comb begin
        rd_word = '0;
        if (in_mode) begin
            rd_word[6:5]        = mode_trig[word_idx];
            rd_word[PRIO_W-1:0] = mode_prio[word_idx];
        end else if (in_vect) begin
            rd_word = vec_tbl[word_idx];
        end else begin
            unique case (bus_addr)
                A_VECT_RD: rd_word = arb_hit ? vec_tbl[win_idx] : spur_vec;
                A_CUR_SRC: rd_word = 32'(cur_src);
                A_PEND:    rd_word = 32'(pend_vec);
                A_ENABLED: rd_word = 32'(en_mask);
                A_CORE:    rd_word = {31'b0, irq_req};
                A_SPUR:    rd_word = spur_vec;
                A_PROTECT: rd_word = {31'b0, prot_mode};
                default:   rd_word = '0;
            endcase
        end
    end

    // Register read data on the edge that samples the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

endmodule

// File: rtl/vic_checker.sv
// Temporal checks on the interrupt controller, bound to vic_top.
// Assumes a read and a write strobe never arrive in the same cycle.
module vic_checker #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned IDX_W   = 5,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [8:0]         bus_addr,
    input logic               irq_req,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] mask,
    input logic [CNT_W-1:0]   depth,
    input logic               prot,
    input logic [IDX_W-1:0]   cur_src
);

    // R7: a request always has an enabled pending source behind it.
    p_req_has_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((pend & mask) != '0));

    // R7: with nothing in service, any enabled pending source raises the request.
    p_empty_stack_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((depth == '0) && ((pend & mask) != '0)) |-> irq_req);

    // R10: the stack never exceeds its depth.
    p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(DEPTH));

    // R10: end-of-interrupt removes exactly one entry when the stack is not empty.
    p_eoi_pops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 9'h130) && (depth != '0)) |=> (depth == $past(depth) - 1'b1));

    // R8: an acknowledging vector read adds one entry.
    p_ack_pushes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && (bus_addr == 9'h100) && !prot && irq_req)
        |=> (depth == $past(depth) + 1'b1));

    // R11: a vector read in protect mode leaves the stack and current source alone.
    p_protect_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && (bus_addr == 9'h100) && prot) |=> ($stable(depth) && $stable(cur_src)));

    // R9: a spurious read pushes nothing and zeroes the current source.
    p_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && (bus_addr == 9'h100) && !prot && !irq_req)
        |=> ($stable(depth) && (cur_src == '0)));

endmodule

bind vic_top vic_checker #(
    .NUM_SRC (NUM_SRC),
    .DEPTH   (NEST_DEPTH),
    .IDX_W   (IDX_W)
) u_vic_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .irq_req  (irq_req),
    .pend     (pend_vec),
    .mask     (en_mask),
    .depth    (nest_depth),
    .prot     (prot_mode),
    .cur_src  (cur_src)
);

// File: tb/tb_vic_top.sv
// Self-checking bench: directed corner cases followed by seeded random nesting rounds.
module tb_vic_top;
    import vic_pkg::*;

    localparam int WD_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_in = '0;
    logic        irq_req;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model for the random section.
    logic [2:0]  m_prio [32];
    logic [31:0] m_vec  [32];
    logic [31:0] m_en;
    logic [31:0] m_pend;
    int          m_stk  [8];
    int          m_dep;

    always #10 clk = ~clk;

    vic_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .irq_req   (irq_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Expected winner: most urgent eligible source, lowest number on ties; -1 if none.
    function automatic int exp_win();
        int best = -1;
        for (int i = 0; i < 32; i++) begin
            if (m_en[i] && m_pend[i] && (m_dep == 0 || int'(m_prio[i]) > m_stk[m_dep-1])) begin
                if (best < 0 || m_prio[i] > m_prio[best]) best = i;
            end
        end
        return best;
    endfunction

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        check("R7 reset irq_req", {31'b0, irq_req}, 0);
        rd(A_ENABLED, d);  check("R4 reset enable word", d, 0);
        rd(A_PEND, d);     check("R5 reset pending word", d, 0);
        rd(A_CORE, d);     check("R7 reset core status", d, 0);
        rd(9'h010, d);     check("R1 reset mode word src4", d, 32'h40);
        rd(A_VECT_RD, d);  check("R9 reset vector read spurious", d, 0);
        rd(A_CUR_SRC, d);  check("R9 reset current source", d, 0);

        // R1 / R2: field layout and forced polarity on internal sources.
        wr(9'h01C, 32'hFFFF_FF65); rd(9'h01C, d); check("R1 mode src7 fields", d, 32'h65);
        wr(9'h01C, 32'h0000_0001); rd(9'h01C, d); check("R2 internal low forced high", d, 32'h41);
        wr(9'h01C, 32'h0000_0020); rd(9'h01C, d); check("R2 internal falling forced rising", d, 32'h60);
        wr(9'h01C, 32'h0000_0040);
        wr(9'h000, 32'h0000_0002); rd(9'h000, d); check("R2 external src0 keeps low", d, 32'h02);

        // R3: vector word.
        wr(9'h0A4, 32'hA5A5_1234); rd(9'h0A4, d); check("R3 vector src9", d, 32'hA5A5_1234);

        // R4: enable and disable commands.
        wr(A_EN_SET, 32'h0000_00F0); wr(A_EN_SET, 32'h0000_0101);
        rd(A_ENABLED, d); check("R4 enable accumulates", d, 32'h1F1);
        wr(A_EN_CLR, 32'h0000_0010);
        rd(A_ENABLED, d); check("R4 disable only ones", d, 32'h1E1);
        wr(A_EN_CLR, 32'hFFFF_FFFF);

        // R6: low level on src0.
        wr(9'h080, 32'h0000_0C00);
        wr(9'h000, 32'h0000_0002);
        settle();
        rd(A_PEND, d); check("R6 low level pending", d, 32'h1);
        wr(A_EN_SET, 32'h1);
        check("R7 irq for low level", {31'b0, irq_req}, 1);
        src_in[0] = 1'b1; settle();
        rd(A_PEND, d); check("R6 low level released", d, 0);
        check("R7 irq drops", {31'b0, irq_req}, 0);

        // R6 / R8: falling edge latches and acknowledge clears it.
        wr(9'h000, 32'h0000_0022);
        src_in[0] = 1'b0; settle();
        src_in[0] = 1'b1; settle();
        rd(A_PEND, d); check("R6 falling edge held", d, 32'h1);
        rd(A_VECT_RD, d); check("R8 vector src0", d, 32'h0000_0C00);
        rd(A_PEND, d); check("R8 ack clears edge latch", d, 0);
        wr(A_EOI, 0);
        wr(A_EN_CLR, 32'h1);

        // R8 / R7: nesting order.
        wr(9'h00C, 32'h45); wr(9'h08C, 32'h300);
        wr(9'h010, 32'h43); wr(9'h090, 32'h400);
        wr(9'h018, 32'h46); wr(9'h098, 32'h600);
        wr(9'h020, 32'h46); wr(9'h0A0, 32'h800);
        wr(A_EN_SET, 32'h0000_0158);
        wr(A_PND_SET, 32'h18);
        rd(A_VECT_RD, d); check("R8 higher priority wins", d, 32'h300);
        rd(A_CUR_SRC, d); check("R8 current source 3", d, 3);
        check("R7 lower level blocked", {31'b0, irq_req}, 0);
        wr(A_PND_SET, 32'h140);
        check("R7 higher level raises", {31'b0, irq_req}, 1);
        rd(A_VECT_RD, d); check("R8 tie goes to lower number", d, 32'h600);
        rd(A_CUR_SRC, d); check("R8 current source 6", d, 6);
        check("R7 equal level blocked", {31'b0, irq_req}, 0);
        wr(A_EOI, 0);
        check("R10 pop reopens equal level", {31'b0, irq_req}, 1);
        rd(A_VECT_RD, d); check("R8 vector src8", d, 32'h800);
        wr(A_EOI, 0); wr(A_EOI, 0);
        rd(A_VECT_RD, d); check("R8 vector src4 after unwind", d, 32'h400);
        wr(A_EOI, 0);
        check("R7 idle", {31'b0, irq_req}, 0);

        // R9: spurious read and EOI on an empty stack.
        wr(A_SPUR, 32'h5A5A_0001);
        rd(A_VECT_RD, d); check("R9 spurious value", d, 32'h5A5A_0001);
        rd(A_CUR_SRC, d); check("R9 current source zero", d, 0);
        wr(A_EOI, 0);

        // R11: protect mode.
        wr(A_PROTECT, 32'h1);
        wr(A_PND_SET, 32'h10);
        rd(A_VECT_RD, d); check("R11 protect read value", d, 32'h400);
        rd(A_PEND, d); check("R11 protect leaves pending", d, 32'h10);
        check("R11 protect leaves request", {31'b0, irq_req}, 1);
        rd(A_CUR_SRC, d); check("R11 protect leaves current source", d, 0);
        wr(A_PROTECT, 32'h0);
        rd(A_VECT_RD, d); check("R11 normal read acknowledges", d, 32'h400);
        rd(A_CUR_SRC, d); check("R11 current source 4", d, 4);

        // R10: eight end-of-interrupt writes unwind a deep stack.
        wr(A_PND_SET, 32'h08); rd(A_VECT_RD, d); check("R8 push src3", d, 32'h300);
        wr(A_PND_SET, 32'h40); rd(A_VECT_RD, d); check("R8 push src6", d, 32'h600);
        wr(9'h028, 32'h47); wr(9'h0A8, 32'hA00); wr(A_EN_SET, 32'h400);
        wr(A_PND_SET, 32'h400); rd(A_VECT_RD, d); check("R8 push src10", d, 32'hA00);
        wr(A_PND_SET, 32'h10);
        check("R7 deep stack blocks", {31'b0, irq_req}, 0);
        for (int k = 0; k < 8; k++) wr(A_EOI, 0);
        check("R10 eight pops empty the stack", {31'b0, irq_req}, 1);
        rd(A_VECT_RD, d); check("R10 src4 after unwind", d, 32'h400);
        wr(A_EOI, 0);

        // R5 / R6: clear-pending and a single rising edge.
        wr(A_PND_SET, 32'h30);
        rd(A_PEND, d); check("R5 set pending", d, 32'h30);
        wr(A_PND_CLR, 32'h10);
        rd(A_PEND, d); check("R5 clear only ones", d, 32'h20);
        wr(A_PND_CLR, 32'hFFFF_FFFF);
        wr(9'h030, 32'h61);
        src_in[12] = 1'b1; settle();
        rd(A_PEND, d); check("R6 rising edge latched", d, 32'h1000);
        wr(A_PND_CLR, 32'h1000); settle();
        rd(A_PEND, d); check("R6 held high is one event", d, 0);

        // R12: level source persists through clear and acknowledge.
        wr(9'h000, 32'h02);
        src_in[0] = 1'b0; settle();
        wr(A_PND_CLR, 32'h1);
        rd(A_PEND, d); check("R12 level survives clear", d, 32'h1);
        wr(A_EN_SET, 32'h1);
        rd(A_VECT_RD, d); check("R12 vector src0", d, 32'h0000_0C00);
        rd(A_PEND, d); check("R12 level survives ack", d, 32'h1);
        check("R7 same level blocked", {31'b0, irq_req}, 0);
        wr(A_EOI, 0);
        check("R7 unblocked after pop", {31'b0, irq_req}, 1);
        wr(9'h000, 32'h40);
        src_in = '0; settle();
        wr(A_EN_CLR, 32'hFFFF_FFFF);
        wr(A_PND_CLR, 32'hFFFF_FFFF);
        for (int k = 0; k < 8; k++) wr(A_EOI, 0);

        // Random rounds: R5, R7, R8, R9 against the bench model.
        for (int r = 0; r < 30; r++) begin
            for (int i = 0; i < 32; i++) begin
                m_prio[i] = 3'($urandom_range(0, 7));
                m_vec[i]  = $urandom;
                wr(9'(i * 4), 32'h40 | 32'(m_prio[i]));
                wr(9'(32'h80 + i * 4), m_vec[i]);
            end
            wr(A_PND_CLR, 32'hFFFF_FFFF);
            wr(A_EN_CLR, 32'hFFFF_FFFF);
            m_dep  = 0;
            m_en   = $urandom;
            m_pend = $urandom & $urandom;
            wr(A_EN_SET, m_en);
            wr(A_PND_SET, m_pend);
            rd(A_PEND, d); check("R5 random pending word", d, m_pend);
            for (int s = 0; s < 12; s++) begin
                int w;
                w = exp_win();
                check("R7 random request", {31'b0, irq_req}, (w >= 0) ? 32'd1 : 32'd0);
                if (m_dep == 0 || $urandom_range(0, 2) != 0) begin
                    rd(A_VECT_RD, d);
                    if (w >= 0) begin
                        check("R8 random vector", d, m_vec[w]);
                        m_stk[m_dep] = int'(m_prio[w]);
                        m_dep++;
                        m_pend[w] = 1'b0;
                        rd(A_CUR_SRC, d); check("R8 random current source", d, 32'(w));
                    end else begin
                        check("R9 random spurious", d, 32'h5A5A_0001);
                    end
                end else begin
                    wr(A_EOI, 0);
                    m_dep--;
                end
            end
            for (int k = 0; k < 8; k++) wr(A_EOI, 0);
        end

        finish_run();
    end

endmodule